// File: doc/BRIEF.md
# Binary to Two-Digit Decimal Display Decoder

This block turns a 4-bit unsigned value into two active-low seven-segment digit patterns. The value 0 to 15 is shown in decimal. A units digit carries the value modulo ten. A tens digit stays dark below ten and shows a "1" from ten upward. The block has no state and no clock. A change on the inputs reaches the segment buses through gates alone.

The four input bits arrive as separate pins `w`, `x`, `y` and `z`, with `w` the most significant. A shared minterm stage decodes them once. Each segment is then formed as a sum of products over the minterms for which that segment must be dark. Each digit is presented as a 7-bit bus whose most significant bit is the top bar and whose least significant bit is the middle bar.

Top module: `bcd2_seg_decoder`

## Requirements
- R1: Segments are active-low, so 0 lights a bar and 1 darkens it. Each bus is ordered top, upper-right, lower-right, bottom, lower-left, upper-left, middle, from bit 6 down to bit 0. The units digit never reads as fully dark (7'b1111111).
- R2: For input 0 the units bus is 7'b0000001 and the tens bus is 7'b1111111.
- R3: For input 1 the units bus is 7'b1001111.
- R4: For inputs 0 to 8 the units bus follows these patterns:
  - 2 = 0010010
  - 3 = 0000110
  - 4 = 1001100
  - 5 = 0100100
  - 6 = 0100000
  - 7 = 0001111
  - 8 = 0000000
- R5: For inputs 10 to 15 the units bus equals the pattern that input minus ten produces.
- R6: Digit nine is drawn without its bottom bar, so input 9 gives a units bus of 7'b0001100.
- R7: For inputs 0 to 9 the tens bus is 7'b1111111 (leading zero suppressed).
- R8: For inputs 10 to 15 the tens bus is 7'b1001111, meaning only the two right-hand bars are lit.
- R9: The outputs are purely combinational. They settle to the new code within the same time step as an input change, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| w | input | 1 | Value bit 3 (most significant) |
| x | input | 1 | Value bit 2 |
| y | input | 1 | Value bit 1 |
| z | input | 1 | Value bit 0 (least significant) |
| a_to_g | output | 7 | Units digit segments, active-low, top bar in bit 6 |
| h_to_n | output | 7 | Tens digit segments, active-low, same bar order |

## Verification
The assertions re-evaluate on every input change and check several rules:
- the tens digit is dark below ten and shows a one from ten upward;
- input zero gives the exact units pattern;
- input eight lights every bar;
- the units digit never goes fully dark.

The exact per-code units patterns, and the folding of 10 to 15 back onto 0 to 5, are shown only by the bench. It sweeps every code, including the odd nine glyph. It also applies random codes and checks that each output settles without any clock edge.

// File: rtl/bcd2_seg_pkg.sv
package bcd2_seg_pkg;
  localparam int VAL_W  = 4;
  localparam int N_CODE = 1 << VAL_W;
  localparam int SEG_W  = 7;

  typedef logic [SEG_W-1:0] seg7_t;

  // Active-low reference patterns used by the tens stage and the checker.
  localparam seg7_t SEG_DARK = 7'b1111111;
  localparam seg7_t SEG_ONE  = 7'b1001111;
  localparam seg7_t SEG_ZERO = 7'b0000001;
  localparam seg7_t SEG_FULL = 7'b0000000;

  // Bit index of each bar inside a digit bus.
  localparam int BAR_TOP = 6;
  localparam int BAR_UR  = 5;
  localparam int BAR_LR  = 4;
  localparam int BAR_BOT = 3;
  localparam int BAR_LL  = 2;
  localparam int BAR_UL  = 1;
  localparam int BAR_MID = 0;
endpackage

// File: rtl/bcd2_minterm_dec.sv
module bcd2_minterm_dec #(
  parameter int IN_W = 4,
  localparam int N = 1 << IN_W
) (
  input  logic [IN_W-1:0] code,
  output logic [N-1:0]    mt
);
  // One product term per code: AND of true or complemented literals.
  for (genvar k = 0; k < N; k++) begin : g_mt
    localparam logic [IN_W-1:0] K = IN_W'(k);
    assign mt[k] = &(code ~^ K);
  end
endmodule

// File: rtl/bcd2_units_sop.sv
module bcd2_units_sop
  import bcd2_seg_pkg::*;
(
  input  logic [N_CODE-1:0] mt,
  output seg7_t             seg
);
  // Each bar is 1 (dark) on the listed minterms.
  assign seg[BAR_TOP] = mt[1] | mt[4] | mt[11] | mt[14];
  assign seg[BAR_UR]  = mt[5] | mt[6] | mt[15];
  assign seg[BAR_LR]  = mt[2] | mt[12];
  assign seg[BAR_BOT] = mt[1] | mt[4] | mt[7] | mt[9] | mt[11] | mt[14];
  assign seg[BAR_LL]  = mt[1] | mt[3] | mt[4] | mt[5] | mt[7] | mt[9]
                      | mt[11] | mt[13] | mt[14] | mt[15];
  assign seg[BAR_UL]  = mt[1] | mt[2] | mt[3] | mt[7] | mt[11] | mt[12] | mt[13];
  assign seg[BAR_MID] = mt[0] | mt[1] | mt[7] | mt[10] | mt[11];
endmodule

// File: rtl/bcd2_tens_sop.sv
module bcd2_tens_sop
  import bcd2_seg_pkg::*;
(
  input  logic [N_CODE-1:0] mt,
  output seg7_t             seg
);
  logic below_ten;

  assign below_ten = mt[0] | mt[1] | mt[2] | mt[3] | mt[4]
                   | mt[5] | mt[6] | mt[7] | mt[8] | mt[9];

  // Only the right-hand bars ever light; they stay dark below ten.
  assign seg[BAR_TOP] = 1'b1;
  assign seg[BAR_UR]  = below_ten;
  assign seg[BAR_LR]  = below_ten;
  assign seg[BAR_BOT] = 1'b1;
  assign seg[BAR_LL]  = 1'b1;
  assign seg[BAR_UL]  = 1'b1;
  assign seg[BAR_MID] = 1'b1;
endmodule

// File: rtl/bcd2_seg_decoder.sv
module bcd2_seg_decoder
  import bcd2_seg_pkg::*;
(
  input  logic       w,
  input  logic       x,
  input  logic       y,
  input  logic       z,
  output logic [6:0] a_to_g,
  output logic [6:0] h_to_n
);
  logic [VAL_W-1:0]  code;
  logic [N_CODE-1:0] mt;
  seg7_t             units_seg;
  seg7_t             tens_seg;

  assign code = {w, x, y, z};

  bcd2_minterm_dec #(.IN_W(VAL_W)) i_mt (
    .code (code),
    .mt   (mt)
  );

  bcd2_units_sop i_units (
    .mt  (mt),
    .seg (units_seg)
  );

  bcd2_tens_sop i_tens (
    .mt  (mt),
    .seg (tens_seg)
  );

  assign a_to_g = units_seg;
  assign h_to_n = tens_seg;
endmodule

// File: rtl/bcd2_seg_checker.sv
module bcd2_seg_checker
  import bcd2_seg_pkg::*;
(
  input logic       w,
  input logic       x,
  input logic       y,
  input logic       z,
  input logic [6:0] a_to_g,
  input logic [6:0] h_to_n
);
  logic [3:0] v;
  assign v = {w, x, y, z};

  always_comb begin
    if (!$isunknown({v, a_to_g, h_to_n})) begin
      a_r7_tens_dark_below_ten: assert (v >= 4'd10 || h_to_n == SEG_DARK)
        else $error("R7 tens not dark for %0d", v);
      a_r8_tens_one_from_ten: assert (v < 4'd10 || h_to_n == SEG_ONE)
        else $error("R8 tens not one for %0d", v);
      a_r2_zero_glyph: assert (v != 4'd0 || a_to_g == SEG_ZERO)
        else $error("R2 zero glyph wrong");
      a_r4_eight_all_lit: assert (v != 4'd8 || a_to_g == SEG_FULL)
        else $error("R4 eight not fully lit");
      a_r1_units_never_dark: assert (a_to_g != SEG_DARK)
        else $error("R1 units dark for %0d", v);
    end
  end
endmodule

bind bcd2_seg_decoder bcd2_seg_checker i_bcd2_seg_checker (
  .w(w), .x(x), .y(y), .z(z), .a_to_g(a_to_g), .h_to_n(h_to_n)
);

// File: tb/test_bcd2_seg_decoder.sv
module test_bcd2_seg_decoder;
  logic clk = 1'b0;
  logic w, x, y, z;
  logic [6:0] a_to_g, h_to_n;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd2_seg_decoder i_bcd2_seg_decoder (
    .w(w), .x(x), .y(y), .z(z), .a_to_g(a_to_g), .h_to_n(h_to_n)
  );

  // Reference glyphs, active-low, bit 6 = top bar ... bit 0 = middle bar.
  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: glyph = 7'b0000001;
      1: glyph = 7'b1001111;
      2: glyph = 7'b0010010;
      3: glyph = 7'b0000110;
      4: glyph = 7'b1001100;
      5: glyph = 7'b0100100;
      6: glyph = 7'b0100000;
      7: glyph = 7'b0001111;
      8: glyph = 7'b0000000;
      default: glyph = 7'b0001100; // nine without bottom bar (R6)
    endcase
  endfunction

  function automatic logic [6:0] exp_units(input int v);
    exp_units = glyph(v % 10);
  endfunction

  function automatic logic [6:0] exp_tens(input int v);
    exp_tens = (v >= 10) ? 7'b1001111 : 7'b1111111;
  endfunction

  function automatic string req_of(input int v);
    if (v == 0) req_of = "R2";
    else if (v == 1) req_of = "R3";
    else if (v == 9) req_of = "R6";
    else if (v >= 10) req_of = "R5";
    else req_of = "R4";
  endfunction

  task automatic check_eq(input string tag, input logic [6:0] act,
                          input logic [6:0] exp, input int v);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s code=%0d actual=%b expected=%b", tag, v, act, exp);
    end
  endtask

  // Apply away from the edge and sample 1 ns later with no clock edge between (R9).
  task automatic apply(input int v);
    @(negedge clk);
    {w, x, y, z} = 4'(v);
    #1;
    check_eq(req_of(v), a_to_g, exp_units(v), v);
    check_eq((v >= 10) ? "R8" : "R7", h_to_n, exp_tens(v), v);
    n_checks++;
    if (a_to_g === 7'b1111111) begin
      n_errors++;
      $display("FAIL R1 code=%0d actual=%b expected=not 1111111", v, a_to_g);
    end
  endtask

  initial begin
    {w, x, y, z} = 4'd0;
    void'($urandom(32'd20240611));
    // Directed: full sweep, then boundary transitions 9<->10, 15->0.
    for (int v = 0; v < 16; v++) apply(v);
    apply(9);  apply(10); apply(9);
    apply(15); apply(0);  apply(1);
    // Random codes.
    for (int i = 0; i < 200; i++) apply(int'($urandom_range(15, 0)));
    // R9: change inputs mid-cycle and check before any clock edge.
    @(posedge clk);
    #0.5;
    {w, x, y, z} = 4'd12;
    #0.5;
    check_eq("R9", a_to_g, exp_units(12), 12);
    check_eq("R9", h_to_n, exp_tens(12), 12);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule